// File: doc/BRIEF.md
# Bridge Control Register File

A bank of 28 word-wide control registers for a host bridge, reached over a simple single-cycle register bus. Software uses it to hold power-on strapping, general configuration, IO and memory timing, address mapping, GPIO, interrupt steering, mailbox words, cache control and timing settings. The hardware that consumes each setting lives elsewhere. This block only stores the values, returns them on reads and applies fixed defaults when reset is asserted.

Two slots behave differently from plain storage. The interrupt enable word cannot be written directly. It changes through a write-to-set alias and a write-to-clear alias, and it drives the `irq_enable` output vector. A write to the general configuration word that takes bit 2 from 0 to 1 raises a one-cycle system reset request.

Addresses are byte offsets inside the bank, and only word-aligned accesses are used. Bank offset 0x00 corresponds to the first control word.

Top module: `bridge_ctl_regs`

## Requirements
- R1: After reset the slots read: 0x00=0x00000C40, 0x04=0x00001384, 0x08=0x2BFF8010, 0x0C=0x255E0091, 0x10=0x00006140, 0x1C=0x000001FF, 0x20=0x000001FF, 0x68=0x00000008, 0x6C=0x10000000. Every other slot reads 0.
- R2: A write to any plain slot stores the full 32-bit value, which a later read returns. The plain slots are every offset 0x00–0x6C except 0x30, 0x34, 0x38 and 0x3C, and they include the mailboxes at 0x40–0x4C.
- R3: A read request accepted on a clock edge sets `rd_valid` high for exactly the next cycle, with `rd_data` holding the addressed word.
- R4: A write to 0x30 stores the value in that slot and ORs it into the enable word. The change is visible on `irq_enable` the cycle after the write.
- R5: A write to 0x34 stores the value in that slot and clears every written 1-bit in the enable word. The change is visible the cycle after the write.
- R6: Writes to 0x38 (enable word) and 0x3C (interrupt status) have no effect. 0x38 reads the enable word and 0x3C reads 0.
- R7: Offsets 0x70 to 0xFC are undefined. Writes there change no slot, and reads there return 0.
- R8: A write to 0x04 whose bit 2 is 1 while the stored bit 2 is 0 stores the value. It also drives `sys_reset_req` high for exactly the one cycle after the write.
- R9: A write to 0x04 that does not take bit 2 from 0 to 1 stores the value and raises no reset request.
- R10: `irq_enable` always equals the enable word, which resets to 0 and changes only through 0x30 and 0x34.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Bus request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset inside the bank (word aligned) |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | DATA_W | Read data |
| irq_enable | output | DATA_W | Current interrupt enable word |
| sys_reset_req | output | 1 | One-cycle system soft-reset request |

## Verification
The assertions assume that the bus issues at most one access per cycle and that a read or write is presented only after the internally synchronised reset has been released. They also assume that the low two address bits are zero. The stimulus meets these assumptions because each access is driven for a single cycle with an idle cycle after it, only word-aligned offsets are used, and the first access comes several cycles after reset is released. Enable-word checks depend on the set and clear aliases being the only writers. The stimulus therefore also writes the read-only and undefined offsets, so that the assertions can confirm those writes leave the enable word unchanged.

// File: rtl/bctl_pkg.sv
package bctl_pkg;

  typedef enum logic [1:0] {
    SK_PLAIN  = 2'd0,
    SK_EN_SET = 2'd1,
    SK_EN_CLR = 2'd2,
    SK_RDONLY = 2'd3
  } slot_kind_e;

  // slot indices whose position the behaviour depends on
  localparam int unsigned IDX_GEN    = 1;
  localparam int unsigned IDX_EN_SET = 12;
  localparam int unsigned IDX_EN_CLR = 13;
  localparam int unsigned IDX_EN     = 14;
  localparam int unsigned IDX_STAT   = 15;
  localparam int unsigned RST_REQ_BIT = 2;

  function automatic slot_kind_e slot_kind(input int unsigned idx);
    case (idx)
      IDX_EN_SET:        return SK_EN_SET;
      IDX_EN_CLR:        return SK_EN_CLR;
      IDX_EN, IDX_STAT:  return SK_RDONLY;
      default:           return SK_PLAIN;
    endcase
  endfunction

  function automatic logic [31:0] slot_reset(input int unsigned idx);
    case (idx)
      0:       return 32'h0000_0C40;
      1:       return 32'h0000_1384;
      2:       return 32'h2BFF_8010;
      3:       return 32'h255E_0091;
      4:       return 32'h0000_6140;
      7:       return 32'h0000_01FF;
      8:       return 32'h0000_01FF;
      26:      return 32'h0000_0008;
      27:      return 32'h1000_0000;
      default: return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/bctl_decode.sv
module bctl_decode #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_SLOTS = 28,
  parameter int unsigned IDX_W     = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] LIMIT = WORD_W'(NUM_SLOTS);

  logic [WORD_W-1:0] word;

  always_comb begin
    word = addr[ADDR_W-1:2];
    hit  = (word < LIMIT);
    idx  = word[IDX_W-1:0];
  end
endmodule

// File: rtl/bctl_slot.sv
module bctl_slot #(
  parameter int unsigned   DATA_W    = 32,
  parameter logic [31:0]   RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (wr_en) q_next = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RESET_VAL[DATA_W-1:0];
    else if (wr_en) q <= q_next;
  end
endmodule

// File: rtl/bctl_inten.sv
module bctl_inten #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] en_q
);
  logic [DATA_W-1:0] en_next;
  logic              upd;

  always_comb begin
    upd     = set_en | clr_en;
    en_next = en_q;
    if (set_en)      en_next = en_q | wdata;
    else if (clr_en) en_next = en_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (upd) en_q <= en_next;
  end
endmodule

// File: rtl/bctl_rstreq.sv
module bctl_rstreq (
  input  logic clk,
  input  logic rst_n,
  input  logic gen_wr,
  input  logic old_bit,
  input  logic new_bit,
  output logic pulse
);
  logic pulse_next;

  always_comb begin
    pulse_next = gen_wr & ~old_bit & new_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else pulse <= pulse_next;
  end
endmodule

// File: rtl/bridge_ctl_regs.sv
module bridge_ctl_regs #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_SLOTS = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] irq_enable,
  output logic              sys_reset_req
);
  import bctl_pkg::*;

  localparam int unsigned IDX_W = $clog2(NUM_SLOTS);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic             hit;
  logic [IDX_W-1:0] idx;

  bctl_decode #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_decode (
    .addr (req_addr),
    .hit  (hit),
    .idx  (idx)
  );

  logic                 wr_acc, rd_acc;
  logic [NUM_SLOTS-1:0] wr_sel;
  logic [DATA_W-1:0]    slot_q [NUM_SLOTS];
  logic [DATA_W-1:0]    en_q;

  always_comb begin
    wr_acc = req_valid & req_write & hit;
    rd_acc = req_valid & ~req_write;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      wr_sel[i] = wr_acc && (idx == IDX_W'(i));
    end
  end

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      if (slot_kind(g) == SK_RDONLY) begin : g_ro
        if (g == IDX_EN) begin : g_en
          assign slot_q[g] = en_q;
        end else begin : g_zero
          assign slot_q[g] = '0;
        end
      end else begin : g_rw
        bctl_slot #(.DATA_W(DATA_W), .RESET_VAL(slot_reset(g))) u_slot (
          .clk   (clk),
          .rst_n (rst_sync_n),
          .wr_en (wr_sel[g]),
          .wdata (req_wdata),
          .q     (slot_q[g])
        );
      end
    end
  endgenerate

  bctl_inten #(.DATA_W(DATA_W)) u_inten (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_en (wr_sel[IDX_EN_SET]),
    .clr_en (wr_sel[IDX_EN_CLR]),
    .wdata  (req_wdata),
    .en_q   (en_q)
  );

  bctl_rstreq u_rstreq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .gen_wr  (wr_sel[IDX_GEN]),
    .old_bit (slot_q[IDX_GEN][RST_REQ_BIT]),
    .new_bit (req_wdata[RST_REQ_BIT]),
    .pulse   (sys_reset_req)
  );

  // read path
  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (hit && (idx == IDX_W'(i))) rd_next = slot_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rd_valid <= 1'b0;
    else rd_valid <= rd_acc;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rd_data <= '0;
    else if (rd_acc) rd_data <= rd_next;
  end

  assign irq_enable = en_q;

endmodule

// File: rtl/bctl_regs_chk.sv
module bctl_regs_chk #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_SLOTS = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] irq_enable,
  input logic              sys_reset_req
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] LIMIT = WORD_W'(NUM_SLOTS);

  logic [WORD_W-1:0] w;
  logic wr, rd, wr_set, wr_clr, wr_gen_hi, wr_ro;
  always_comb begin
    w         = req_addr[ADDR_W-1:2];
    wr        = req_valid & req_write;
    rd        = req_valid & ~req_write;
    wr_set    = wr && (w == WORD_W'(12));
    wr_clr    = wr && (w == WORD_W'(13));
    wr_ro     = wr && ((w == WORD_W'(14)) || (w == WORD_W'(15)) || (w >= LIMIT));
    wr_gen_hi = wr && (w == WORD_W'(1)) && req_wdata[2];
  end

  assert_rd_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rd_valid);
  assert_rd_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rd_valid);
  assert_set_or_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> irq_enable == ($past(irq_enable) | $past(req_wdata)));
  assert_clr_and_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> irq_enable == ($past(irq_enable) & ~$past(req_wdata)));
  assert_ro_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ro |=> $stable(irq_enable));
  assert_undef_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (w >= LIMIT)) |=> rd_data == '0);
  assert_req_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> $past(wr_gen_hi));
  assert_req_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |=> !sys_reset_req);
  assert_en_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr) |=> $stable(irq_enable));
endmodule

bind bridge_ctl_regs bctl_regs_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .req_valid     (req_valid),
  .req_write     (req_write),
  .req_addr      (req_addr),
  .req_wdata     (req_wdata),
  .rd_valid      (rd_valid),
  .rd_data       (rd_data),
  .irq_enable    (irq_enable),
  .sys_reset_req (sys_reset_req)
);

// File: tb/bridge_ctl_regs_bench.sv
module bridge_ctl_regs_bench;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int NS = 28;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rd_valid;
  logic [DW-1:0] rd_data, irq_enable;
  logic          sys_reset_req;

  always #4 clk = ~clk;  // 125 MHz

  bridge_ctl_regs u_bridge_ctl_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .irq_enable(irq_enable), .sys_reset_req(sys_reset_req)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic [DW-1:0] model [NS];
  logic [DW-1:0] en_model;

  function automatic logic [DW-1:0] dflt(input int i);
    case (i)
      0: return 32'hC40;       1: return 32'h1384;
      2: return 32'h2BFF8010;  3: return 32'h255E0091;
      4: return 32'h6140;      7: return 32'h1FF;
      8: return 32'h1FF;       26: return 32'h8;
      27: return 32'h10000000; default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when read data appears
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk(1, 0, "R3 unexpected rd_valid");
      else chk(rd_data, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NS; i++) model[i] = dflt(i);
    en_model = '0;

    chk(irq_enable, 0, "R10 enable after reset");
    chk({31'b0, sys_reset_req}, 0, "R8 no request after reset");

    // R1: defaults
    for (int i = 0; i < NS; i++) bus_rd(AW'(i*4), model[i], $sformatf("R1 default slot %0d", i));

    // R3: valid lasts one cycle
    @(negedge clk);
    chk({31'b0, rd_valid}, 0, "R3 rd_valid drops");

    // R2: plain slots including mailboxes
    for (int i = 16; i < 20; i++) begin
      model[i] = 32'hA5A50000 | DW'(i);
      bus_wr(AW'(i*4), model[i]);
    end
    model[0] = 32'hFFFF_FFFF; bus_wr(8'h00, model[0]);
    model[27] = 32'h1234_5678; bus_wr(8'h6C, model[27]);
    for (int i = 16; i < 20; i++) bus_rd(AW'(i*4), model[i], "R2 mailbox readback");
    bus_rd(8'h00, model[0], "R2 slot 0 readback");
    bus_rd(8'h6C, model[27], "R2 last slot readback");

    // R4: set alias
    bus_wr(8'h30, 32'h0000_00F0); en_model |= 32'h0000_00F0;
    chk(irq_enable, en_model, "R4 set first");
    bus_wr(8'h30, 32'h0F00_0003); en_model |= 32'h0F00_0003;
    chk(irq_enable, en_model, "R4 set second");
    bus_rd(8'h30, 32'h0F00_0003, "R4 set alias stored");

    // R5: clear alias
    bus_wr(8'h34, 32'h0000_0030); en_model &= ~32'h0000_0030;
    chk(irq_enable, en_model, "R5 clear bits");
    bus_rd(8'h34, 32'h0000_0030, "R5 clear alias stored");

    // R6: read-only slots
    bus_wr(8'h38, 32'hFFFF_FFFF);
    chk(irq_enable, en_model, "R6 enable write ignored");
    bus_wr(8'h3C, 32'hDEAD_BEEF);
    bus_rd(8'h38, en_model, "R6 enable readback");
    bus_rd(8'h3C, 32'h0, "R6 status reads zero");

    // R7: undefined offsets
    bus_wr(8'h70, 32'hCAFE_0001);
    bus_wr(8'h80, 32'hCAFE_0002);
    bus_wr(8'hFC, 32'hCAFE_0003);
    chk(irq_enable, en_model, "R7 undefined write leaves enable");
    bus_rd(8'h70, 32'h0, "R7 undefined read 0x70");
    bus_rd(8'hFC, 32'h0, "R7 undefined read 0xFC");
    bus_rd(8'h00, model[0], "R7 no alias onto slot 0");

    // R9 / R8: general config bit 2
    bus_wr(8'h04, 32'h0000_1380);
    chk({31'b0, sys_reset_req}, 0, "R9 clearing bit 2");
    bus_wr(8'h04, 32'h0000_1384);
    chk({31'b0, sys_reset_req}, 1, "R8 rising bit 2 request");
    @(negedge clk);
    chk({31'b0, sys_reset_req}, 0, "R8 request single cycle");
    bus_wr(8'h04, 32'h0000_FFFF);
    chk({31'b0, sys_reset_req}, 0, "R9 bit 2 held high");
    bus_rd(8'h04, 32'h0000_FFFF, "R9 value stored");

    chk(irq_enable, en_model, "R10 enable unchanged by other writes");

    repeat (3) @(negedge clk);
    chk(DW'(exp_q.size()), 0, "R3 all reads returned");
    finish_up();
  end
endmodule